// File: doc/BRIEF.md
# Buffered-Duty Complementary PWM Channel

This block generates one complementary pair of PWM outputs from a triangular carrier. Two up/down counters move in lockstep. The leading counter always sits a fixed dead-time value above the lagging counter. The carrier rises until the leading counter reaches the period value plus one, which is the peak. It then falls until the lagging counter reaches zero, which is the underflow, and rises again. A normal-phase output is derived from the leading counter and a counter-phase output from the lagging counter. Both are compared against one active compare value, so the two outputs are separated by a gap as wide as the dead time.

Software-side logic may write a new duty value into a buffer at any cycle. The active compare value only takes that buffer value at a transfer instant, so a duty change never produces a partial pulse. A 2-bit mode input picks the transfer instant. Two situations override that choice:

- A buffer value at or above the period is moved only at underflow, and a sticky overrange flag is raised.
- While the flag is set, every transfer waits for underflow. The first transfer of a value between 1 and period-1 clears the flag, and mode-selected timing resumes after it.

Top module: `cpwm_buffered_duty`

## Requirements
- R1: After reset, the lagging counter reads 0, the leading counter equals `dead`, the carrier is rising, the active compare value and the overrange flag are 0, and both PWM outputs are 0.
- R2: The leading counter always equals the lagging counter plus `dead` (with `dead` <= `period`). While `run` is high, the carrier moves one step per clock.
  - Rising: the counters increment until the cycle in which the leading counter equals `period`+1 (the peak). On that edge the carrier turns to falling and the counters decrement.
  - Falling: the counters decrement until the cycle in which the lagging counter is 0 (the underflow). On that edge the carrier turns to rising and the counters increment.
  - `cnt_down` is 1 while falling.
- R3: `buf_we` loads `buf_din` into the buffer at any clock. The active compare value changes only on the clock edge that ends a peak or underflow cycle, and it then takes the buffer contents held before that edge.
- R4: Outside the override cases, mode selects the transfer instant:
  - 2'b00 and 2'b01 transfer at underflow.
  - 2'b10 transfers at both peak and underflow.
  - 2'b11 transfers at peak.
- R5: A buffer value >= `period` is transferred only at underflow, whatever the mode. That transfer sets the overrange flag.
- R6: While the overrange flag is set, transfers happen only at underflow. A transferred value in 1..`period`-1 clears the flag. A transferred value of 0 leaves the flag set. Once the flag is clear, R4 timing applies again.
- R7: Each output is registered and reflects the previous cycle's counters and compare value:
  - The normal-phase condition is "leading counter < compare", and the counter-phase condition is "lagging counter >= compare".
  - A polarity input of 1 drives the condition as active high; a polarity input of 0 drives it inverted.
- R8: With both polarity inputs at 1, the two outputs are never high in the same cycle.
- R9: While `run` is low, the counters, the direction and the active compare value hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Carrier count enable |
| period | input | CNT_W | Period value; the peak is reached at period+1 |
| dead | input | CNT_W | Dead-time offset of the leading counter |
| mode | input | 2 | Transfer instant select |
| buf_we | input | 1 | Buffer write strobe |
| buf_din | input | CNT_W | Duty value written into the buffer |
| pol_norm | input | 1 | Normal-phase polarity, 1 = active high |
| pol_cntr | input | 1 | Counter-phase polarity, 1 = active high |
| pwm_norm | output | 1 | Normal-phase output |
| pwm_cntr | output | 1 | Counter-phase output |
| cnt_lead | output | CNT_W | Leading counter value |
| cnt_lag | output | CNT_W | Lagging counter value |
| cnt_down | output | 1 | Carrier falling |
| cmp_active | output | CNT_W | Active compare value |
| ovr_sticky | output | 1 | Overrange flag |

## Verification
The bench builds the block with an 8-bit counter width, a period of 10 and a dead time of 2. At these values one carrier cycle lasts about 20 clocks, so every transfer mode, both override cases and buffer writes at every carrier phase are reached many times in a short run. The 8-bit width also allows buffer values far above the period, such as 200, as well as a value exactly equal to the period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    XM_UFLOW_A = 2'b00,
    XM_UFLOW_B = 2'b01,
    XM_BOTH    = 2'b10,
    XM_PEAK    = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic peak;
    logic uflow;
  } carrier_evt_t;

endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  input  logic [W-1:0] dead,
  output logic [W-1:0] cnt_lead,
  output logic [W-1:0] cnt_lag,
  output logic         down,
  output carrier_evt_t evt
);

  localparam logic [W:0]   ONE_X = (W+1)'(1);
  localparam logic [W-1:0] STEP  = W'(1);

  logic [W-1:0] lag_q, lag_d;
  logic         down_q, down_d;
  logic [W:0]   top_val;

  assign top_val  = {1'b0, period} + ONE_X;
  assign cnt_lag  = lag_q;
  assign cnt_lead = lag_q + dead;
  assign down     = down_q;

  always_comb begin
    evt.peak  = run && !down_q && ({1'b0, cnt_lead} >= top_val);
    evt.uflow = run && down_q && (lag_q == '0);
  end

  always_comb begin
    lag_d  = lag_q;
    down_d = down_q;
    if (run) begin
      if (!down_q) begin
        if (evt.peak) begin
          down_d = 1'b1;
          lag_d  = lag_q - STEP;
        end else begin
          lag_d  = lag_q + STEP;
        end
      end else begin
        if (evt.uflow) begin
          down_d = 1'b0;
          lag_d  = lag_q + STEP;
        end else begin
          lag_d  = lag_q - STEP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lag_q  <= '0;
      down_q <= 1'b0;
    end else if (run) begin
      lag_q  <= lag_d;
      down_q <= down_d;
    end
  end

endmodule

// File: rtl/cpwm_xfer.sv
module cpwm_xfer
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode,
  input  logic         buf_we,
  input  logic [W-1:0] buf_din,
  input  logic [W-1:0] period,
  input  carrier_evt_t evt,
  output logic [W-1:0] cmp,
  output logic         sticky
);

  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] cmp_q, cmp_d;
  logic         stk_q, stk_d;
  logic         ovr, forced, sel, hit;

  assign cmp    = cmp_q;
  assign sticky = stk_q;

  always_comb begin
    ovr    = (buf_q >= period);
    forced = ovr || stk_q;
    case (mode)
      XM_PEAK: sel = evt.peak;
      XM_BOTH: sel = evt.peak || evt.uflow;
      default: sel = evt.uflow;
    endcase
    hit = forced ? evt.uflow : sel;
  end

  always_comb begin
    buf_d = buf_we ? buf_din : buf_q;
    cmp_d = cmp_q;
    stk_d = stk_q;
    if (hit) begin
      cmp_d = buf_q;
      if (ovr) begin
        stk_d = 1'b1;
      end else if (buf_q != '0) begin
        stk_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_we) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      stk_q <= 1'b0;
    end else if (hit) begin
      cmp_q <= cmp_d;
      stk_q <= stk_d;
    end
  end

endmodule

// File: rtl/cpwm_phase_out.sv
module cpwm_phase_out #(
  parameter int W        = 16,
  parameter bit LAG_SIDE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         pol,
  output logic         pwm
);

  logic active;
  logic pwm_q, pwm_d;

  generate
    if (LAG_SIDE) begin : g_lag
      assign active = (cnt >= cmp);
    end else begin : g_lead
      assign active = (cnt < cmp);
    end
  endgenerate

  always_comb begin
    pwm_d = pol ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/cpwm_buffered_duty.sv
module cpwm_buffered_duty
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] dead,
  input  logic [1:0]       mode,
  input  logic             buf_we,
  input  logic [CNT_W-1:0] buf_din,
  input  logic             pol_norm,
  input  logic             pol_cntr,
  output logic             pwm_norm,
  output logic             pwm_cntr,
  output logic [CNT_W-1:0] cnt_lead,
  output logic [CNT_W-1:0] cnt_lag,
  output logic             cnt_down,
  output logic [CNT_W-1:0] cmp_active,
  output logic             ovr_sticky
);

  localparam int NPH = 2;

  carrier_evt_t     evt;
  logic [CNT_W-1:0] lead_w, lag_w, cmp_w;
  logic [NPH-1:0]   pol_v, pwm_v;

  cpwm_carrier #(.W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .period   (period),
    .dead     (dead),
    .cnt_lead (lead_w),
    .cnt_lag  (lag_w),
    .down     (cnt_down),
    .evt      (evt)
  );

  cpwm_xfer #(.W(CNT_W)) u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (xfer_mode_e'(mode)),
    .buf_we  (buf_we),
    .buf_din (buf_din),
    .period  (period),
    .evt     (evt),
    .cmp     (cmp_w),
    .sticky  (ovr_sticky)
  );

  assign pol_v = {pol_cntr, pol_norm};

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    cpwm_phase_out #(.W(CNT_W), .LAG_SIDE(g == 1)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   ((g == 1) ? lag_w : lead_w),
      .cmp   (cmp_w),
      .pol   (pol_v[g]),
      .pwm   (pwm_v[g])
    );
  end

  assign pwm_norm   = pwm_v[0];
  assign pwm_cntr   = pwm_v[1];
  assign cnt_lead   = lead_w;
  assign cnt_lag    = lag_w;
  assign cmp_active = cmp_w;

endmodule

// File: rtl/cpwm_buffered_duty_chk.sv
module cpwm_buffered_duty_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic [W-1:0] period,
  input logic         pol_norm,
  input logic         pol_cntr,
  input logic         pwm_norm,
  input logic         pwm_cntr,
  input logic [W-1:0] cnt_lead,
  input logic [W-1:0] cnt_lag,
  input logic         cnt_down,
  input logic [W-1:0] cmp_active,
  input logic         ovr_sticky
);

  localparam logic [W:0]   ONE_X = (W+1)'(1);
  localparam logic [W-1:0] STEP  = W'(1);

  logic at_peak, at_uf;
  assign at_peak = run && !cnt_down && ({1'b0, cnt_lead} >= ({1'b0, period} + ONE_X));
  assign at_uf   = run && cnt_down && (cnt_lag == '0);

  AST_LAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt_lag == $past(cnt_lag) + STEP) || (cnt_lag == $past(cnt_lag) - STEP)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_lag) && $stable(cnt_down) && $stable(cmp_active)); // R9

  AST_CMP_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_peak || at_uf) |=> $stable(cmp_active)); // R3

  AST_OVR_AT_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_sticky) |-> $past(at_uf)); // R5

  AST_STICKY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sticky && !at_uf) |=> $stable(cmp_active)); // R6

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_norm && pol_cntr && $past(pol_norm) && $past(pol_cntr)) |-> !(pwm_norm && pwm_cntr)); // R8

endmodule

bind cpwm_buffered_duty cpwm_buffered_duty_chk #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .period     (period),
  .pol_norm   (pol_norm),
  .pol_cntr   (pol_cntr),
  .pwm_norm   (pwm_norm),
  .pwm_cntr   (pwm_cntr),
  .cnt_lead   (cnt_lead),
  .cnt_lag    (cnt_lag),
  .cnt_down   (cnt_down),
  .cmp_active (cmp_active),
  .ovr_sticky (ovr_sticky)
);

// File: tb/cpwm_buffered_duty_test.sv
module cpwm_buffered_duty_test;

  localparam int W   = 8;
  localparam int PER = 10;
  localparam int DT  = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run;
  logic [W-1:0] period, dead, buf_din;
  logic [1:0]   mode;
  logic         buf_we, pol_norm, pol_cntr;
  logic         pwm_norm, pwm_cntr, cnt_down, ovr_sticky;
  logic [W-1:0] cnt_lead, cnt_lag, cmp_active;

  int total = 0;
  int bad   = 0;
  string tag = "R2";

  // behavioural reference state
  int m_lag, m_down, m_cmp, m_buf, m_stk, m_p, m_q;

  always #4 clk = ~clk;

  cpwm_buffered_duty #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period), .dead(dead),
    .mode(mode), .buf_we(buf_we), .buf_din(buf_din),
    .pol_norm(pol_norm), .pol_cntr(pol_cntr),
    .pwm_norm(pwm_norm), .pwm_cntr(pwm_cntr),
    .cnt_lead(cnt_lead), .cnt_lag(cnt_lag), .cnt_down(cnt_down),
    .cmp_active(cmp_active), .ovr_sticky(ovr_sticky)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int lead, peak, uf, ovr, hit, sel;
    int n_lag, n_down, n_cmp, n_stk, n_buf;
    lead  = m_lag + DT;
    peak  = (run && !m_down && lead >= PER + 1) ? 1 : 0;
    uf    = (run && m_down && m_lag == 0) ? 1 : 0;
    n_lag = m_lag; n_down = m_down;
    if (run) begin
      if (peak != 0)    begin n_down = 1; n_lag = m_lag - 1; end
      else if (uf != 0) begin n_down = 0; n_lag = m_lag + 1; end
      else if (m_down != 0) n_lag = m_lag - 1;
      else n_lag = m_lag + 1;
    end
    ovr = (m_buf >= PER) ? 1 : 0;
    if (mode == 2'b11)      sel = peak;
    else if (mode == 2'b10) sel = (peak != 0 || uf != 0) ? 1 : 0;
    else                    sel = uf;
    hit = (ovr != 0 || m_stk != 0) ? uf : sel;
    n_cmp = m_cmp; n_stk = m_stk;
    if (hit != 0) begin
      n_cmp = m_buf;
      if (ovr != 0) n_stk = 1;
      else if (m_buf != 0) n_stk = 0;
    end
    n_buf = buf_we ? int'(buf_din) : m_buf;
    m_p = ((lead < m_cmp) == (pol_norm == 1'b1)) ? 1 : 0;
    m_q = ((m_lag >= m_cmp) == (pol_cntr == 1'b1)) ? 1 : 0;
    m_lag = n_lag; m_down = n_down; m_cmp = n_cmp; m_stk = n_stk; m_buf = n_buf;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    check(int'(cnt_lag) == m_lag, "R2", "cnt_lag", int'(cnt_lag), m_lag);
    check(int'(cnt_lead) == m_lag + DT, "R2", "cnt_lead", int'(cnt_lead), m_lag + DT);
    check(int'(cnt_down) == m_down, "R2", "cnt_down", int'(cnt_down), m_down);
    check(int'(cmp_active) == m_cmp, tag, "cmp_active", int'(cmp_active), m_cmp);
    check(int'(ovr_sticky) == m_stk, "R6", "ovr_sticky", int'(ovr_sticky), m_stk);
    check(int'(pwm_norm) == m_p, "R7", "pwm_norm", int'(pwm_norm), m_p);
    check(int'(pwm_cntr) == m_q, "R7", "pwm_cntr", int'(pwm_cntr), m_q);
    if (pol_norm && pol_cntr)
      check(!(pwm_norm && pwm_cntr), "R8", "overlap", int'(pwm_norm & pwm_cntr), 0);
  endtask

  task automatic run_for(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_buf(input int v);
    buf_din = W'(v);
    buf_we  = 1'b1;
    tick();
    buf_we  = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b1; period = W'(PER); dead = W'(DT);
    mode = 2'b11; buf_we = 1'b0; buf_din = '0; pol_norm = 1'b1; pol_cntr = 1'b1;
    m_lag = 0; m_down = 0; m_cmp = 0; m_buf = 0; m_stk = 0; m_p = 0; m_q = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt_lag == '0, "R1", "cnt_lag", int'(cnt_lag), 0);
    check(int'(cnt_lead) == DT, "R1", "cnt_lead", int'(cnt_lead), DT);
    check(!cnt_down, "R1", "cnt_down", int'(cnt_down), 0);
    check(cmp_active == '0, "R1", "cmp_active", int'(cmp_active), 0);
    check(!ovr_sticky, "R1", "ovr_sticky", int'(ovr_sticky), 0);
    check(!pwm_norm && !pwm_cntr, "R1", "pwm", int'({pwm_cntr, pwm_norm}), 0);
    rst_n = 1'b1;

    tag = "R2"; run_for(25);
    tag = "R3"; write_buf(5); run_for(7); write_buf(6); run_for(40);
    tag = "R4";
    mode = 2'b00; write_buf(3); run_for(45);
    mode = 2'b01; write_buf(7); run_for(45);
    mode = 2'b10; write_buf(2); run_for(13); write_buf(8); run_for(45);
    mode = 2'b11; write_buf(4); run_for(45);
    tag = "R5";
    write_buf(PER); run_for(45);
    mode = 2'b10; write_buf(200); run_for(45);
    tag = "R6";
    mode = 2'b11; write_buf(4); run_for(45);
    write_buf(6); run_for(45);
    write_buf(12); run_for(30); write_buf(0); run_for(45);
    write_buf(9); run_for(45); write_buf(3); run_for(45);
    tag = "R9";
    run = 1'b0; write_buf(5); run_for(15);
    run = 1'b1; run_for(45);
    tag = "R7";
    pol_norm = 1'b0; pol_cntr = 1'b0; write_buf(6); run_for(45);
    pol_norm = 1'b1; pol_cntr = 1'b0; write_buf(1); run_for(45);
    pol_norm = 1'b0; pol_cntr = 1'b1; write_buf(9); run_for(45);
    pol_norm = 1'b1; pol_cntr = 1'b1;
    tag = "R8"; write_buf(5); run_for(45);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule